// File: doc/BRIEF.md
# Frame-Clock Ratio Detector

This block works out which of eight standard telephony bit-clock rates is driving it. It does so by counting bit-clock cycles between consecutive rising edges of an 8 kHz frame strobe. The strobe is synchronous to the bit clock. The legal counts per frame are 32, 64, 96, 128, 192, 256, 512 and 1024, which correspond to 256 kHz through 8.192 MHz. The block turns an exact match into a 3-bit rate code. It also gives the multiplication factor a downstream synthesizer would need to bring the bit clock up to 16.384 MHz, that is, 2048 cycles per frame.

After each reset the block takes exactly one good measurement and then holds it. It throws away the partial stretch from reset to the first strobe edge. It measures the first full frame after that edge. If the count is not one of the eight legal values, it raises an error flag, keeps valid low and tries again on the next frame. Once a good code is captured, the code and the factor stay frozen until the next reset.

Top module: `fcr_ratio_detect`

## Requirements
- R1: While reset is asserted and just after it is released, rate_code_o, mult_o, valid_o and err_o are all zero.
- R2: The measured period is the number of clk_i cycles between two consecutive rising edges of fsync_i, whatever the high time of the strobe.
- R3: The interval from reset release to the first rising edge of fsync_i is discarded. A single rising edge after reset produces neither valid_o nor err_o.
- R4: A period of exactly 32, 64, 96, 128, 192, 256, 512 or 1024 cycles sets valid_o with rate_code_o = 0, 1, 2, 3, 4, 5, 6 or 7 respectively. valid_o is low at the first falling clock edge after fsync_i is first sampled high at the closing edge, and high one clock later.
- R5: While valid_o is high, mult_o equals the integer part of 2048 divided by the matched period: 64, 32, 21, 16, 10, 8, 4 or 2 for codes 0 to 7. While valid_o is low, mult_o is zero.
- R6: Any other period sets err_o and leaves valid_o low. The next frame is measured again, and a legal result there clears err_o and sets valid_o.
- R7: A period longer than the counter range (4095 cycles) counts as illegal. It never wraps around to a legal value.
- R8: Once valid_o is high, rate_code_o, mult_o, valid_o and err_o do not change until reset, whatever frames follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; the counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | 8 kHz frame strobe, synchronous to clk_i |
| rate_code_o | output | 3 | Detected rate code, 0 = slowest |
| mult_o | output | 7 | Multiplication factor to 2048 cycles per frame |
| valid_o | output | 1 | A legal period has been captured |
| err_o | output | 1 | Last measured period was not legal |

## Verification
The bench runs every legal period and, for each one, the periods one cycle either side of it. A classifier off by one, or a counter that counts edges rather than intervals, therefore flags a legal rate as an error or accepts a neighbour. A period of 4160 cycles would wrap to 64 in a non-saturating 12-bit counter and come out as a false valid code. The bench also gives a lone strobe edge after reset, where a design that measured from reset would report something. A legal frame followed by frames of other lengths exposes a design that does not freeze its result. An illegal frame followed by a legal one shows whether the retry and the clearing of the error flag work. Frames with a 50% high time catch edge detection that counts strobe high time rather than rise-to-rise spacing.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int NUM_RATES    = 8;
  localparam int CODE_W       = $clog2(NUM_RATES);
  localparam int BASE_RATIO   = 32;
  localparam int MAX_RATIO    = 1024;
  localparam int TARGET_RATIO = 2048;  // 16.384 MHz over 8 kHz
  localparam int CNT_W        = $clog2(MAX_RATIO + 1) + 1;
  localparam int MULT_W       = $clog2(TARGET_RATIO / BASE_RATIO + 1);

  // cycles per frame for each code, ascending
  function automatic int ratio_of(input int code);
    if (code < 4)       return BASE_RATIO * (code + 1);
    else if (code == 4) return BASE_RATIO * 6;
    else                return (BASE_RATIO * 8) << (code - 5);
  endfunction

  function automatic int factor_of(input int code);
    return TARGET_RATIO / ratio_of(code);
  endfunction
endpackage

// File: rtl/fcr_fsync_edge.sv
module fcr_fsync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  output logic rise_o
);
  logic smp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= fsync_i;
      prev_q <= smp_q;
    end
  end

  assign rise_o = smp_q & ~prev_q;

  a_r2_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fcr_period_cnt.sv
module fcr_period_cnt #(
  parameter int CNT_W = fcr_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] period_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  localparam logic [CNT_W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b1;
    end else if (cnt_q != SAT) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // first edge only arms: partial frame from reset is dropped
  assign done_o   = rise_i & armed_q;
  assign period_o = cnt_q;

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> (cnt_q == CNT_W'(1)));
  a_r7_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SAT && !rise_i) |=> (cnt_q == SAT));
endmodule

// File: rtl/fcr_rate_match.sv
module fcr_rate_match #(
  parameter int CNT_W     = fcr_pkg::CNT_W,
  parameter int NUM_RATES = fcr_pkg::NUM_RATES,
  parameter int CODE_W    = fcr_pkg::CODE_W,
  parameter int MULT_W    = fcr_pkg::MULT_W
) (
  input  logic [CNT_W-1:0]  period_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o,
  output logic [MULT_W-1:0] mult_o
);
  logic [NUM_RATES-1:0] match;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_cmp
    localparam logic [CNT_W-1:0] LEGAL = CNT_W'(fcr_pkg::ratio_of(i));
    assign match[i] = (period_i == LEGAL);
  end

  always_comb begin
    code_o = '0;
    mult_o = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (match[i]) begin
        code_o = CODE_W'(i);
        mult_o = MULT_W'(fcr_pkg::factor_of(i));
      end
    end
  end

  assign hit_o = |match;

  always_comb begin
    a_r4_unique_match: assert ($onehot0(match));
  end
endmodule

// File: rtl/fcr_ratio_detect.sv
module fcr_ratio_detect (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fsync_i,
  output logic [2:0] rate_code_o,
  output logic [6:0] mult_o,
  output logic       valid_o,
  output logic       err_o
);
  import fcr_pkg::*;

  logic              rise;
  logic [CNT_W-1:0]  period;
  logic              meas_done;
  logic              hit;
  logic [CODE_W-1:0] code_d;
  logic [MULT_W-1:0] mult_d;
  logic [CODE_W-1:0] code_q;
  logic [MULT_W-1:0] mult_q;
  logic              valid_q, err_q;

  fcr_fsync_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .rise_o  (rise)
  );

  fcr_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .period_o (period),
    .done_o   (meas_done)
  );

  fcr_rate_match #(
    .CNT_W(CNT_W), .NUM_RATES(NUM_RATES), .CODE_W(CODE_W), .MULT_W(MULT_W)
  ) u_match (
    .period_i (period),
    .hit_o    (hit),
    .code_o   (code_d),
    .mult_o   (mult_d)
  );

  // single capture per reset; retry while not valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      mult_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (meas_done && !valid_q) begin
      valid_q <= hit;
      err_q   <= ~hit;
      if (hit) begin
        code_q <= code_d;
        mult_q <= mult_d;
      end
    end
  end

  assign rate_code_o = code_q;
  assign mult_o      = valid_q ? mult_q : '0;
  assign valid_o     = valid_q;
  assign err_o       = err_q;

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (valid_o && !err_o && $stable(rate_code_o) && $stable(mult_o)));
  a_r6_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);
  a_r5_mult_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (mult_o == '0));
  a_r4_capture_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(meas_done));
  a_r5_mult_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mult_o != '0));
endmodule

// File: tb/fcr_ratio_detect_bench.sv
`timescale 1ns/1ps
module fcr_ratio_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic [2:0] code;
  logic [6:0] mult;
  logic       valid, err;
  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fcr_ratio_detect u_fcr_ratio_detect (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync),
    .rate_code_o(code), .mult_o(mult), .valid_o(valid), .err_o(err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic int legal(input int k);
    if (k < 4) return 32 * (k + 1);
    if (k == 4) return 192;
    return 256 << (k - 5);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset();
    fsync = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame(input int n, input int h);
    fsync = 1'b1;
    repeat (h) @(negedge clk);
    fsync = 1'b0;
    repeat (n - h) @(negedge clk);
  endtask

  // rising edge closing a frame; returns two cycles later
  task automatic close_rise(input string req, input bit chk_lat);
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    if (chk_lat) chk({req, " latency low"}, valid, 0);
    @(negedge clk);
  endtask

  task automatic expect_legal(input string req, input int k);
    chk({req, " valid"}, valid, 1);
    chk({req, " code"}, code, k);
    chk({req, " mult"}, mult, 2048 / legal(k));
    chk({req, " err"}, err, 0);
  endtask

  task automatic expect_bad(input string req);
    chk({req, " err"}, err, 1);
    chk({req, " valid"}, valid, 0);
    chk({req, " mult"}, mult, 0);
  endtask

  initial begin
    // R1 reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 code", code, 0);
    chk("R1 mult", mult, 0);
    chk("R1 valid", valid, 0);
    chk("R1 err", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", valid, 0);
    chk("R1 err after release", err, 0);

    // R4/R5 every legal period, with the capture latency
    for (int k = 0; k < 8; k++) begin
      do_reset();
      frame(legal(k), 1);
      close_rise("R4", 1'b1);
      expect_legal("R4 R5", k);
    end

    // R6 neighbours of every legal period are errors
    for (int k = 0; k < 8; k++) begin
      for (int d = -1; d <= 1; d += 2) begin
        do_reset();
        frame(legal(k) + d, 1);
        close_rise("R6", 1'b0);
        expect_bad("R6 neighbour");
      end
    end

    // R2 wide strobe, rise-to-rise spacing
    for (int k = 3; k < 8; k++) begin
      do_reset();
      frame(legal(k), legal(k) / 2);
      close_rise("R2", 1'b0);
      expect_legal("R2 wide strobe", k);
    end

    // R3 lone edge after reset
    do_reset();
    repeat (57) @(negedge clk);
    frame(2000, 1);
    chk("R3 valid", valid, 0);
    chk("R3 err", err, 0);

    // R7 over-range period that would wrap to 64
    do_reset();
    frame(4096 + 64, 1);
    close_rise("R7", 1'b0);
    expect_bad("R7 saturate");

    // R6 retry: illegal then legal
    do_reset();
    frame(100, 1);
    close_rise("R6", 1'b0);
    expect_bad("R6 first try");
    repeat (126) @(negedge clk);
    close_rise("R6", 1'b0);
    expect_legal("R6 retry", 3);

    // R8 frozen after capture
    do_reset();
    frame(96, 1);
    close_rise("R8", 1'b0);
    expect_legal("R8 capture", 2);
    repeat (94) @(negedge clk);
    frame(200, 1);
    frame(512, 1);
    frame(33, 1);
    frame(1024, 1);
    close_rise("R8", 1'b0);
    expect_legal("R8 frozen", 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule